// File: doc/BRIEF.md
# Multi-Field Header Rule Matcher

This block decides which rules in a rule set accept a packet, judging by its header alone. An upstream parser sends the header fields one at a time. Each field carries four things: a kind number, a width class (8, 16 or 32 bits) and a value, plus packet-start and packet-end markers.

The value is looked up in the associative slot table for its width class. On a hit, the class and the slot number together address a shared combination memory. That memory holds one bit per rule, and a set bit means the rule accepts that value. The word read from it is ORed with the field kind's don't-care word, whose set bits mark rules that accept any value of that field. On a miss, only the don't-care word applies. The result for each field is ANDed into a running rule vector, which is reset to all ones at the start of each packet.

When the last field of a packet has been taken in, the block presents the final vector with a one-cycle done strobe. That vector feeds the payload matcher and the traffic-volume logic downstream. Three host write ports load the slot tables, the combination memory and the don't-care memory.

Top module: `hdr_rule_match`

## Requirements
- R1: After reset, `rule_done` is 0, `rule_vec` is all zeros, every slot in all three tables is empty, and both bitmap memories read as zero.
- R2: Width classes are coded 0 = 8 bit, 1 = 16 bit and 2 = 32 bit. A field of class c is compared only against the valid slots of class c's table, and only on the low 8, 16 or 32 bits of `fld_value`. Higher bits of the value are ignored.
- R3: On a hit in slot s of class c, the field result is the combination word at address c*SLOTS+s, ORed with the don't-care word of `fld_kind`. Bit n of any rule vector belongs to rule n, so bit 0 is the first rule.
- R4: On a lookup miss, the field result is the don't-care word of `fld_kind` alone.
- R5: If several valid slots of one table hold the same value, the lowest-numbered slot wins.
- R6: A field accepted with `fld_first` set starts from an all-ones vector. Any other field ANDs its result into the running vector. One cycle after a field with `fld_last` is accepted, `rule_vec` shows the final vector and `rule_done` is 1 for exactly that cycle. `rule_vec` holds its value until the next packet end.
- R7: While `fld_valid` is 0, the markers, kind, class and value have no effect.
- R8: Class code 3 never hits, so a field with that class contributes only its don't-care word.
- R9: A host write takes effect on the clock edge that performs it. A field accepted on that same edge still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fld_valid | input | 1 | Field present this cycle |
| fld_first | input | 1 | Field is the first of its packet |
| fld_last | input | 1 | Field is the last of its packet |
| fld_kind | input | KIND_W (5) | Field kind, selects the don't-care word |
| fld_class | input | 2 | Width class: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = none |
| fld_value | input | 32 | Field value, right-aligned |
| tbl_wr_en | input | 1 | Write one slot-table entry |
| tbl_wr_class | input | 2 | Table to write |
| tbl_wr_slot | input | SLOT_W (4) | Slot to write |
| tbl_wr_valid | input | 1 | New valid flag of the slot |
| tbl_wr_value | input | 32 | New key, right-aligned |
| cmb_wr_en | input | 1 | Write one combination word |
| cmb_wr_addr | input | CMB_AW (6) | Word address, class*SLOTS+slot |
| cmb_wr_data | input | RULES (32) | Rule-acceptance bits |
| dc_wr_en | input | 1 | Write one don't-care word |
| dc_wr_kind | input | KIND_W (5) | Field kind to write |
| dc_wr_data | input | RULES (32) | Don't-care bits |
| rule_vec | output | RULES (32) | Final rule vector of the last packet |
| rule_done | output | 1 | One-cycle strobe: `rule_vec` just updated |

## Verification
The lookups and the merge are combinational, so the running vector, `rule_vec` and `rule_done` all change on the edge that accepts a field. Host writes likewise land on the edge that carries them. The bench drives every input on the falling edge and reads the outputs on the next falling edge, half a cycle after the edge that accepted the last field, when `rule_done` must be high. One falling edge later it reads again to see that the strobe has dropped and that the vector has held. The same-edge write case drives the write and a field together, so the old and the new contents show up in two consecutive packets.

// File: rtl/hrm_pkg.sv
// Shared definitions for the header rule matcher.
// Assumes three key widths; class code 3 is reserved and never hits.
package hrm_pkg;

    typedef enum logic [1:0] {
        CLS_B8   = 2'd0,
        CLS_B16  = 2'd1,
        CLS_B32  = 2'd2,
        CLS_NONE = 2'd3
    } fld_class_e;

    localparam int NUM_CLASSES = 3;
    localparam int VAL_W       = 32;

    // Key width in bits of a given class number.
    function automatic int class_width(input int cls);
        case (cls)
            0:       return 8;
            1:       return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/hrm_cam.sv
// Associative slot table for one key width.
// Each slot holds a valid flag and a key. The lookup is combinational and
// reports the lowest matching slot. Assumes one host write per cycle; a
// write becomes visible after the edge that performs it.
module hrm_cam #(
    parameter int KEY_W  = 8,
    parameter int SLOTS  = 16,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic              lk_en,
    input  logic [KEY_W-1:0]  lk_key,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot
);

    logic [KEY_W-1:0] key_q [SLOTS];
    logic [SLOTS-1:0] vld_q;
    logic [SLOTS-1:0] match;
    logic [SLOTS-1:0] below_mask;

    // Slot storage: host writes one slot's flag and key per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < SLOTS; i++) key_q[i] <= '0;
        end else if (wr_en) begin
            vld_q[wr_slot] <= wr_valid;
            key_q[wr_slot] <= wr_key;
        end
    end

    // Per-slot comparators, one per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = lk_en && vld_q[g] && (key_q[g] == lk_key);
    end

    // Priority encoder: the lowest matching slot wins.
    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_slot = SLOT_W'(i);
            end
        end
    end

    // Mask of the slots below the reported one, used by a check.
    assign below_mask = (SLOTS'(1) << hit_slot) - SLOTS'(1);

    AST_HIT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (vld_q[hit_slot] && key_q[hit_slot] == lk_key)); // R2
    AST_LOWEST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match & below_mask) == '0)); // R5
    AST_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |-> !hit); // R8

endmodule

// File: rtl/hrm_bitmap_mem.sv
// Register-file memory of rule-wide words, one write port and one
// combinational read port. Cleared by reset. Writes to addresses at or
// above DEPTH are dropped, and reads there return zero.
module hrm_bitmap_mem #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             wr_ok;
    logic             rd_ok;

    // Address range guard, built only when DEPTH leaves addresses unused.
    if (DEPTH == (1 << AW)) begin : g_full
        assign wr_ok = 1'b1;
        assign rd_ok = 1'b1;
    end else begin : g_part
        assign wr_ok = (32'(wr_addr) < DEPTH);
        assign rd_ok = (32'(rd_addr) < DEPTH);
    end

    // Word storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en && wr_ok) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Combinational read, zero outside the range.
    always_comb begin
        rd_data = '0;
        if (rd_ok) rd_data = mem_q[rd_addr];
    end

endmodule

// File: rtl/hrm_accum.sv
// Running rule vector. Restarts from all ones on a first field, ANDs every
// accepted field result, and publishes the vector with a one-cycle strobe
// on the edge that takes in a last field. Assumes every packet opens with
// a first field.
module hrm_accum #(
    parameter int RULES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fld_valid,
    input  logic             fld_first,
    input  logic             fld_last,
    input  logic [RULES-1:0] fld_res,
    output logic [RULES-1:0] rule_vec,
    output logic             rule_done
);

    logic [RULES-1:0] acc_q;
    logic [RULES-1:0] base;
    logic [RULES-1:0] acc_nxt;

    // Start value for this field, then the merged vector.
    assign base    = fld_first ? '1 : acc_q;
    assign acc_nxt = base & fld_res;

    // Running vector, output register and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '1;
            rule_vec  <= '0;
            rule_done <= 1'b0;
        end else begin
            rule_done <= fld_valid && fld_last;
            if (fld_valid) begin
                acc_q <= acc_nxt;
                if (fld_last) rule_vec <= acc_nxt;
            end
        end
    end

    AST_ACC_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_valid && !fld_first) |=> ((acc_q & ~$past(acc_q)) == '0)); // R6
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rule_done |-> $stable(rule_vec)); // R6

endmodule

// File: rtl/hdr_rule_match.sv
// Multi-field header rule matcher, top level.
// It has one slot table per width class, a combination memory addressed by
// class*SLOTS+slot, a don't-care memory addressed by field kind, and the
// running-vector accumulator. Assumes SLOTS is a power of two and that the
// upstream parser marks each packet's first and last field.
module hdr_rule_match #(
    parameter int RULES  = 32,
    parameter int SLOTS  = 16,
    parameter int FKINDS = 32,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int KIND_W    = $clog2(FKINDS),
    localparam int CMB_DEPTH = hrm_pkg::NUM_CLASSES * SLOTS,
    localparam int CMB_AW    = $clog2(CMB_DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fld_valid,
    input  logic                      fld_first,
    input  logic                      fld_last,
    input  logic [KIND_W-1:0]         fld_kind,
    input  logic [1:0]                fld_class,
    input  logic [hrm_pkg::VAL_W-1:0] fld_value,
    input  logic                      tbl_wr_en,
    input  logic [1:0]                tbl_wr_class,
    input  logic [SLOT_W-1:0]         tbl_wr_slot,
    input  logic                      tbl_wr_valid,
    input  logic [hrm_pkg::VAL_W-1:0] tbl_wr_value,
    input  logic                      cmb_wr_en,
    input  logic [CMB_AW-1:0]         cmb_wr_addr,
    input  logic [RULES-1:0]          cmb_wr_data,
    input  logic                      dc_wr_en,
    input  logic [KIND_W-1:0]         dc_wr_kind,
    input  logic [RULES-1:0]          dc_wr_data,
    output logic [RULES-1:0]          rule_vec,
    output logic                      rule_done
);
    import hrm_pkg::*;

    logic [NUM_CLASSES-1:0] cam_hit;
    logic [SLOT_W-1:0]      cam_slot [NUM_CLASSES];
    logic                   sel_hit;
    logic [SLOT_W-1:0]      sel_slot;
    logic [CMB_AW-1:0]      cmb_rd_addr;
    logic [RULES-1:0]       cmb_word;
    logic [RULES-1:0]       dc_word;
    logic [RULES-1:0]       fld_res;

    // One slot table per width class, keyed on the low bits of the value.
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_tbl
        localparam int KW = class_width(c);
        hrm_cam #(
            .KEY_W (KW),
            .SLOTS (SLOTS),
            .SLOT_W(SLOT_W)
        ) u_cam (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tbl_wr_en && (tbl_wr_class == 2'(c))),
            .wr_slot (tbl_wr_slot),
            .wr_valid(tbl_wr_valid),
            .wr_key  (tbl_wr_value[KW-1:0]),
            .lk_en   (fld_class == 2'(c)),
            .lk_key  (fld_value[KW-1:0]),
            .hit     (cam_hit[c]),
            .hit_slot(cam_slot[c])
        );
    end

    // Pick the table of the field's class; class 3 never hits.
    always_comb begin
        sel_hit  = 1'b0;
        sel_slot = '0;
        case (fld_class_e'(fld_class))
            CLS_B8:  begin sel_hit = cam_hit[0]; sel_slot = cam_slot[0]; end
            CLS_B16: begin sel_hit = cam_hit[1]; sel_slot = cam_slot[1]; end
            CLS_B32: begin sel_hit = cam_hit[2]; sel_slot = cam_slot[2]; end
            default: begin sel_hit = 1'b0;       sel_slot = '0;          end
        endcase
    end

    // Combination word address: class times table depth, plus slot.
    assign cmb_rd_addr = CMB_AW'(int'(fld_class) * SLOTS + int'(sel_slot));

    hrm_bitmap_mem #(
        .DEPTH(CMB_DEPTH),
        .WIDTH(RULES),
        .AW   (CMB_AW)
    ) u_cmb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmb_wr_en),
        .wr_addr(cmb_wr_addr),
        .wr_data(cmb_wr_data),
        .rd_addr(cmb_rd_addr),
        .rd_data(cmb_word)
    );

    hrm_bitmap_mem #(
        .DEPTH(FKINDS),
        .WIDTH(RULES),
        .AW   (KIND_W)
    ) u_dc (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (dc_wr_en),
        .wr_addr(dc_wr_kind),
        .wr_data(dc_wr_data),
        .rd_addr(fld_kind),
        .rd_data(dc_word)
    );

    // Field result: don't-care word, widened by the combination word on a hit.
    assign fld_res = sel_hit ? (cmb_word | dc_word) : dc_word;

    hrm_accum #(
        .RULES(RULES)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .fld_valid(fld_valid),
        .fld_first(fld_first),
        .fld_last (fld_last),
        .fld_res  (fld_res),
        .rule_vec (rule_vec),
        .rule_done(rule_done)
    );

    AST_MISS_DC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_valid && fld_first && fld_last && !sel_hit)
        |=> (rule_vec == $past(dc_word))); // R4

endmodule

// File: tb/hdr_rule_match_test.sv
// Directed bench for hdr_rule_match. Inputs change on the falling edge and
// outputs are read on the falling edge after the accepting rising edge.
module hdr_rule_match_test;

    localparam int RULES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fld_valid = 0, fld_first = 0, fld_last = 0;
    logic [4:0]  fld_kind = '0;
    logic [1:0]  fld_class = '0;
    logic [31:0] fld_value = '0;
    logic        tbl_wr_en = 0;
    logic [1:0]  tbl_wr_class = '0;
    logic [3:0]  tbl_wr_slot = '0;
    logic        tbl_wr_valid = 0;
    logic [31:0] tbl_wr_value = '0;
    logic        cmb_wr_en = 0;
    logic [5:0]  cmb_wr_addr = '0;
    logic [31:0] cmb_wr_data = '0;
    logic        dc_wr_en = 0;
    logic [4:0]  dc_wr_kind = '0;
    logic [31:0] dc_wr_data = '0;
    logic [31:0] rule_vec;
    logic        rule_done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hdr_rule_match uut (
        .clk(clk), .rst_n(rst_n),
        .fld_valid(fld_valid), .fld_first(fld_first), .fld_last(fld_last),
        .fld_kind(fld_kind), .fld_class(fld_class), .fld_value(fld_value),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_class(tbl_wr_class),
        .tbl_wr_slot(tbl_wr_slot), .tbl_wr_valid(tbl_wr_valid),
        .tbl_wr_value(tbl_wr_value),
        .cmb_wr_en(cmb_wr_en), .cmb_wr_addr(cmb_wr_addr), .cmb_wr_data(cmb_wr_data),
        .dc_wr_en(dc_wr_en), .dc_wr_kind(dc_wr_kind), .dc_wr_data(dc_wr_data),
        .rule_vec(rule_vec), .rule_done(rule_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic [1:0] cls, input logic [3:0] slot,
                          input logic vld, input logic [31:0] val);
        @(negedge clk);
        tbl_wr_en = 1; tbl_wr_class = cls; tbl_wr_slot = slot;
        tbl_wr_valid = vld; tbl_wr_value = val;
        @(negedge clk);
        tbl_wr_en = 0;
    endtask

    task automatic wr_cmb(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cmb_wr_en = 1; cmb_wr_addr = a; cmb_wr_data = d;
        @(negedge clk);
        cmb_wr_en = 0;
    endtask

    task automatic wr_dc(input logic [4:0] k, input logic [31:0] d);
        @(negedge clk);
        dc_wr_en = 1; dc_wr_kind = k; dc_wr_data = d;
        @(negedge clk);
        dc_wr_en = 0;
    endtask

    // Presents one field for one cycle; returns on the falling edge after acceptance.
    task automatic send(input logic [4:0] k, input logic [1:0] cls,
                        input logic [31:0] val, input logic first, input logic last);
        @(negedge clk);
        fld_valid = 1; fld_kind = k; fld_class = cls; fld_value = val;
        fld_first = first; fld_last = last;
        @(negedge clk);
        fld_valid = 0; fld_first = 0; fld_last = 0;
    endtask

    task automatic t_reset;
        check("R1 done after reset", 32'(rule_done), 32'd0);
        check("R1 vector after reset", rule_vec, 32'd0);
        send(5'd1, 2'd0, 32'h06, 1, 1);   // empty tables and memories
        check("R1 empty memories give zero", rule_vec, 32'd0);
    endtask

    task automatic t_setup;
        wr_tbl(2'd0, 4'd2, 1, 32'h06);
        wr_tbl(2'd1, 4'd0, 1, 32'd80);
        wr_tbl(2'd2, 4'd5, 1, 32'h0A00_0001);
        wr_cmb(6'd2,  32'h0000_000F);
        wr_cmb(6'd16, 32'h0000_0005);
        wr_cmb(6'd37, 32'h0000_0003);
        wr_dc(5'd1, 32'h0000_0100);
        wr_dc(5'd2, 32'h0000_0200);
        wr_dc(5'd3, 32'h0000_0008);
    endtask

    task automatic t_basic;
        send(5'd1, 2'd0, 32'h06, 1, 0);
        check("R6 no done mid packet", 32'(rule_done), 32'd0);
        send(5'd2, 2'd1, 32'd80, 0, 0);
        send(5'd3, 2'd2, 32'h0A00_0001, 0, 1);
        check("R3 three-field hit, rule 0 in bit 0", rule_vec, 32'h0000_0001);
        check("R6 done after last", 32'(rule_done), 32'd1);
        @(negedge clk);
        check("R6 done one cycle", 32'(rule_done), 32'd0);
        check("R6 vector held", rule_vec, 32'h0000_0001);
    endtask

    task automatic t_miss;
        send(5'd2, 2'd1, 32'd81, 1, 1);
        check("R4 miss gives dont-care only", rule_vec, 32'h0000_0200);
    endtask

    task automatic t_width;
        send(5'd1, 2'd0, 32'hFFFF_FF06, 1, 1);
        check("R2 upper bits ignored on 8-bit class", rule_vec, 32'h0000_010F);
        send(5'd1, 2'd1, 32'h06, 1, 1);
        check("R2 other class table not searched", rule_vec, 32'h0000_0100);
    endtask

    task automatic t_lowest;
        wr_tbl(2'd0, 4'd7, 1, 32'h06);
        wr_cmb(6'd7, 32'hF000_0000);
        send(5'd1, 2'd0, 32'h06, 1, 1);
        check("R5 lowest slot wins", rule_vec, 32'h0000_010F);
        wr_tbl(2'd0, 4'd2, 0, 32'h06);
        send(5'd1, 2'd0, 32'h06, 1, 1);
        check("R5 next slot after invalidate", rule_vec, 32'hF000_0100);
        wr_tbl(2'd0, 4'd2, 1, 32'h06);
    endtask

    task automatic t_class3;
        send(5'd1, 2'd3, 32'h06, 1, 1);
        check("R8 class 3 never hits", rule_vec, 32'h0000_0100);
    endtask

    task automatic t_gap;
        send(5'd1, 2'd0, 32'h06, 1, 0);
        @(negedge clk);
        fld_last = 1; fld_first = 1; fld_kind = 5'd2; fld_class = 2'd1; fld_value = 32'd81;
        @(negedge clk);
        check("R7 idle markers give no done", 32'(rule_done), 32'd0);
        check("R7 idle markers keep vector", rule_vec, 32'h0000_0100);
        fld_last = 0; fld_first = 0;
        send(5'd3, 2'd2, 32'h0, 0, 1);
        check("R7 accumulation kept across gap", rule_vec, 32'h0000_0008);
    endtask

    task automatic t_backtoback;
        @(negedge clk);
        fld_valid = 1; fld_first = 1; fld_last = 1;
        fld_kind = 5'd2; fld_class = 2'd1; fld_value = 32'd81;
        @(negedge clk);
        check("R6 first packet of pair", rule_vec, 32'h0000_0200);
        fld_kind = 5'd1; fld_class = 2'd0; fld_value = 32'h06;
        @(negedge clk);
        fld_valid = 0; fld_first = 0; fld_last = 0;
        check("R6 restart at first field", rule_vec, 32'h0000_010F);
        check("R6 done on second packet", 32'(rule_done), 32'd1);
    endtask

    task automatic t_same_edge;
        @(negedge clk);
        cmb_wr_en = 1; cmb_wr_addr = 6'd2; cmb_wr_data = 32'h0000_00F0;
        fld_valid = 1; fld_first = 1; fld_last = 1;
        fld_kind = 5'd1; fld_class = 2'd0; fld_value = 32'h06;
        @(negedge clk);
        cmb_wr_en = 0;
        fld_valid = 0; fld_first = 0; fld_last = 0;
        check("R9 same-edge field sees old word", rule_vec, 32'h0000_010F);
        send(5'd1, 2'd0, 32'h06, 1, 1);
        check("R9 later field sees new word", rule_vec, 32'h0000_01F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_basic();
        t_miss();
        t_width();
        t_lowest();
        t_class3();
        t_gap();
        t_backtoback();
        t_same_edge();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule